// File: doc/BRIEF.md
# Directory Coherence Entry Controller

This block keeps the coherence directory for a small set of memory blocks in a multiprocessor. Each entry records one of three states (no cached copy, read-only copies, one writable copy) and a sharer vector with one bit per cache. A miss or write-back from a cache arrives as a request naming the kind of request, the requesting cache and the block's entry index. The controller updates that entry and answers with the commands the rest of the memory system must carry out: supply the block's value to the requester, pull the current data from the owning cache, invalidate a set of caches, and which cache owns the block.

One request is taken per clock. The entry is read, the commands are decided and the entry is rewritten in the same cycle. The acknowledgement, carrying the commands, appears on the registered outputs in the following cycle. A request that breaks the protocol raises an error flag. It issues no command and leaves the entry as it was. The interconnect, the data path for the block contents and the caches are outside the block.

Top module: `coh_dir_top`

## Requirements
- R1: After reset every entry holds no cached copy with an empty sharer vector, and all acknowledgement outputs are low.
- R2: A read miss to an entry with no cached copy returns the value without fetch or invalidation, and leaves the entry read-only with the requester as its only sharer.
- R3: A write miss to an entry with no cached copy returns the value without fetch or invalidation, and leaves the entry writable, owned by the requester.
- R4: A read miss to a read-only entry returns the value with no fetch or invalidation, and adds the requester to the sharer vector.
- R5: A write miss to a read-only entry returns the value and invalidates every sharer except the requester. The entry becomes writable, owned by the requester alone.
- R6: A read miss to a writable entry raises fetch with the owner's id and returns the value. The entry becomes read-only with the owner and the requester as sharers.
- R7: A write miss to a writable entry raises fetch with the owner's id and returns the value. It invalidates the owner unless the owner is the requester, and the entry stays writable, owned by the requester.
- R8: A write-back from the owner of a writable entry raises no command and no error, and leaves the entry with no cached copy and an empty sharer vector.
- R9: A write-back to an entry that is not writable, a write-back from a cache other than the owner, and a request of the reserved kind all raise the error flag. None of them returns, fetches or invalidates, and the entry is left unchanged.
- R10: Request kind encoding: 2'b00 read miss, 2'b01 write miss, 2'b10 write-back, 2'b11 reserved. The acknowledgement for a request appears exactly one cycle after it. A cycle without a request gives ackValid low with every command output low in the next cycle.
- R11: Each entry index has its own state and sharer vector. A request to one index never changes another.
- R12: The invalidation mask never contains the requesting cache. The owner id output is zero whenever fetch is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A request is presented this cycle |
| reqKind | input | 2 | Request kind (see R10) |
| reqCache | input | CID_W | Id of the requesting cache |
| reqIndex | input | IDX_W | Directory entry addressed |
| ackValid | output | 1 | Acknowledgement of the previous cycle's request |
| ackReturn | output | 1 | Send the block value to the requester |
| ackFetch | output | 1 | Pull the block's data from its owner |
| ackInvMask | output | NUM_CACHES | Caches to invalidate, one bit per cache |
| ackOwner | output | CID_W | Id of the owner to fetch from |
| ackError | output | 1 | Request violated the protocol |

## Verification
Fetch from the owner and invalidation land in the same acknowledgement when a write miss hits a writable entry. This is provoked for every pairing of owner and requester: a write miss from one cache takes ownership, then a write miss comes from each cache in turn. The mask must hold exactly the owner bit, or be empty when the owner asks again, while ackOwner names the owner. Both are judged against a bench model that rebuilds each entry arithmetically from the request history. Read misses and write-backs to writable entries, and write misses to read-only entries, are swept the same way across all caches.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;

  typedef enum logic [1:0] {
    DIR_UNC = 2'd0,
    DIR_SHR = 2'd1,
    DIR_EXC = 2'd2
  } dirState_t;

  typedef enum logic [1:0] {
    REQ_READ  = 2'd0,
    REQ_WRITE = 2'd1,
    REQ_WBACK = 2'd2,
    REQ_RSVD  = 2'd3
  } reqKind_t;

  // Strobes from control to the datapath for one request
  typedef struct packed {
    logic      tabWrite;
    dirState_t nextState;
    logic      shareClear;
    logic      shareSetOnly;
    logic      shareAdd;
    logic      sendReturn;
    logic      sendFetch;
    logic      sendInval;
    logic      sendOwner;
    logic      flagError;
  } dirStrobe_t;

endpackage

// File: rtl/coh_dir_ctrl.sv
module coh_dir_ctrl
  import coh_dir_pkg::*;
(
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  input  dirState_t  curState,
  input  logic       reqIsSharer,
  output dirStrobe_t strobe
);

  always_comb begin
    strobe           = '0;
    strobe.nextState = curState;
    if (reqValid) begin
      case (reqKind)
        REQ_READ: begin
          strobe.tabWrite   = 1'b1;
          strobe.sendReturn = 1'b1;
          case (curState)
            DIR_EXC: begin
              strobe.sendFetch = 1'b1;
              strobe.sendOwner = 1'b1;
              strobe.shareAdd  = 1'b1;
              strobe.nextState = DIR_SHR;
            end
            DIR_SHR: begin
              strobe.shareAdd  = 1'b1;
            end
            default: begin
              strobe.shareSetOnly = 1'b1;
              strobe.nextState    = DIR_SHR;
            end
          endcase
        end
        REQ_WRITE: begin
          strobe.tabWrite     = 1'b1;
          strobe.sendReturn   = 1'b1;
          strobe.shareSetOnly = 1'b1;
          strobe.nextState    = DIR_EXC;
          case (curState)
            DIR_EXC: begin
              strobe.sendFetch = 1'b1;
              strobe.sendOwner = 1'b1;
              strobe.sendInval = 1'b1;
            end
            DIR_SHR: begin
              strobe.sendInval = 1'b1;
            end
            default: ;
          endcase
        end
        REQ_WBACK: begin
          // in the writable state the sharer vector holds the owner only
          if (curState == DIR_EXC && reqIsSharer) begin
            strobe.tabWrite   = 1'b1;
            strobe.shareClear = 1'b1;
            strobe.nextState  = DIR_UNC;
          end else begin
            strobe.flagError  = 1'b1;
          end
        end
        default: begin
          strobe.flagError = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/coh_dir_path.sv
module coh_dir_path
  import coh_dir_pkg::*;
#(
  parameter int NUM_CACHES  = 4,
  parameter int NUM_ENTRIES = 4,
  localparam int CID_W = (NUM_CACHES  > 1) ? $clog2(NUM_CACHES)  : 1,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [CID_W-1:0]      reqCache,
  input  logic [IDX_W-1:0]      reqIndex,
  input  dirStrobe_t            strobe,
  output dirState_t             curState,
  output logic                  reqIsSharer,
  output logic                  ackValid,
  output logic                  ackReturn,
  output logic                  ackFetch,
  output logic [NUM_CACHES-1:0] ackInvMask,
  output logic [CID_W-1:0]      ackOwner,
  output logic                  ackError
);

  dirState_t             stateArr [NUM_ENTRIES];
  logic [NUM_CACHES-1:0] shareArr [NUM_ENTRIES];
  logic [NUM_CACHES-1:0] curShare;
  logic [NUM_CACHES-1:0] reqMask;
  logic [NUM_CACHES-1:0] nextShare;
  logic [CID_W-1:0]      ownerIdx;

  // per-entry storage
  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    dirState_t             entState;
    logic [NUM_CACHES-1:0] entShare;
    logic                  entHit;

    assign entHit = strobe.tabWrite && (reqIndex == IDX_W'(e));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entState <= DIR_UNC;
        entShare <= '0;
      end else if (entHit) begin
        entState <= strobe.nextState;
        entShare <= nextShare;
      end
    end

    assign stateArr[e] = entState;
    assign shareArr[e] = entShare;
  end

  assign curState    = stateArr[reqIndex];
  assign curShare    = shareArr[reqIndex];
  assign reqMask     = NUM_CACHES'(1) << reqCache;
  assign reqIsSharer = curShare[reqCache];

  // owner position; a writable entry has one bit set
  always_comb begin
    ownerIdx = '0;
    for (int i = 0; i < NUM_CACHES; i++) begin
      if (curShare[i]) ownerIdx = CID_W'(i);
    end
  end

  always_comb begin
    if (strobe.shareClear)        nextShare = '0;
    else if (strobe.shareSetOnly) nextShare = reqMask;
    else if (strobe.shareAdd)     nextShare = curShare | reqMask;
    else                          nextShare = curShare;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackValid   <= 1'b0;
      ackReturn  <= 1'b0;
      ackFetch   <= 1'b0;
      ackInvMask <= '0;
      ackOwner   <= '0;
      ackError   <= 1'b0;
    end else begin
      ackValid   <= reqValid;
      ackReturn  <= strobe.sendReturn;
      ackFetch   <= strobe.sendFetch;
      ackInvMask <= strobe.sendInval ? (curShare & ~reqMask) : '0;
      ackOwner   <= strobe.sendOwner ? ownerIdx : '0;
      ackError   <= strobe.flagError;
    end
  end

endmodule

// File: rtl/coh_dir_top.sv
module coh_dir_top
  import coh_dir_pkg::*;
#(
  parameter int NUM_CACHES  = 4,
  parameter int NUM_ENTRIES = 4,
  localparam int CID_W = (NUM_CACHES  > 1) ? $clog2(NUM_CACHES)  : 1,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [1:0]            reqKind,
  input  logic [CID_W-1:0]      reqCache,
  input  logic [IDX_W-1:0]      reqIndex,
  output logic                  ackValid,
  output logic                  ackReturn,
  output logic                  ackFetch,
  output logic [NUM_CACHES-1:0] ackInvMask,
  output logic [CID_W-1:0]      ackOwner,
  output logic                  ackError
);

  dirStrobe_t strobe;
  dirState_t  curState;
  logic       reqIsSharer;

  coh_dir_ctrl u_ctrl (
    .reqValid    (reqValid),
    .reqKind     (reqKind),
    .curState    (curState),
    .reqIsSharer (reqIsSharer),
    .strobe      (strobe)
  );

  coh_dir_path #(
    .NUM_CACHES  (NUM_CACHES),
    .NUM_ENTRIES (NUM_ENTRIES)
  ) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqCache    (reqCache),
    .reqIndex    (reqIndex),
    .strobe      (strobe),
    .curState    (curState),
    .reqIsSharer (reqIsSharer),
    .ackValid    (ackValid),
    .ackReturn   (ackReturn),
    .ackFetch    (ackFetch),
    .ackInvMask  (ackInvMask),
    .ackOwner    (ackOwner),
    .ackError    (ackError)
  );

endmodule

// File: rtl/coh_dir_chk.sv
module coh_dir_chk #(
  parameter int NUM_CACHES  = 4,
  parameter int NUM_ENTRIES = 4,
  localparam int CID_W = (NUM_CACHES  > 1) ? $clog2(NUM_CACHES)  : 1,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  reqValid,
  input logic [1:0]            reqKind,
  input logic [CID_W-1:0]      reqCache,
  input logic [IDX_W-1:0]      reqIndex,
  input logic                  ackValid,
  input logic                  ackReturn,
  input logic                  ackFetch,
  input logic [NUM_CACHES-1:0] ackInvMask,
  input logic [CID_W-1:0]      ackOwner,
  input logic                  ackError
);

  // R10
  ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> ackValid);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!ackValid && !ackReturn && !ackFetch && !ackError && ackInvMask == '0));

  // R12
  inval_skips_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (ackInvMask[$past(reqCache)] == 1'b0));

  // R12
  owner_only_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ackFetch |-> (ackOwner == '0));

  // R9
  error_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackError |-> (!ackReturn && !ackFetch && ackInvMask == '0));

  // R9
  rsvd_error_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == 2'b11) |=> ackError);

  // R6
  fetch_returns_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackFetch |-> ackReturn);

  // R8
  wback_no_return_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == 2'b10) |=> !ackReturn);

  // R5
  inval_on_write_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind != 2'b01) |=> (ackInvMask == '0));

endmodule

bind coh_dir_top coh_dir_chk #(
  .NUM_CACHES  (NUM_CACHES),
  .NUM_ENTRIES (NUM_ENTRIES)
) u_chk (.*);

// File: tb/coh_dir_top_test.sv
module coh_dir_top_test;

  localparam int NC = 4;
  localparam int NE = 4;
  localparam int CW = 2;
  localparam int XW = 2;
  localparam int S_UNC = 0, S_SHR = 1, S_EXC = 2;

  logic          clk = 1'b0;
  logic          rstN;
  logic          reqValid;
  logic [1:0]    reqKind;
  logic [CW-1:0] reqCache;
  logic [XW-1:0] reqIndex;
  logic          ackValid, ackReturn, ackFetch, ackError;
  logic [NC-1:0] ackInvMask;
  logic [CW-1:0] ackOwner;

  int checks = 0;
  int fails  = 0;
  int          mSt [NE];
  logic [NC-1:0] mSh [NE];

  always #5 clk = ~clk;

  coh_dir_top #(.NUM_CACHES(NC), .NUM_ENTRIES(NE)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqCache(reqCache), .reqIndex(reqIndex), .ackValid(ackValid),
    .ackReturn(ackReturn), .ackFetch(ackFetch), .ackInvMask(ackInvMask),
    .ackOwner(ackOwner), .ackError(ackError)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int lowBit(logic [NC-1:0] v);
    for (int i = NC - 1; i >= 0; i--) if (v[i]) lowBit = i;
  endfunction

  task automatic doReset();
    rstN = 1'b0; reqValid = 1'b0; reqKind = '0; reqCache = '0; reqIndex = '0;
    for (int e = 0; e < NE; e++) begin mSt[e] = S_UNC; mSh[e] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1", "ackValid", ackValid, 0);
    check("R1", "ackReturn", ackReturn, 0);
    check("R1", "ackInvMask", ackInvMask, 0);
    check("R1", "ackError", ackError, 0);
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic doReq(int kind, int c, int idx);
    int st, nst, own, eRet, eFet, eOwn, eErr;
    logic [NC-1:0] sh, nsh, rm, eInv;
    string tag;
    st = mSt[idx]; sh = mSh[idx]; rm = NC'(1) << c; own = lowBit(sh);
    nst = st; nsh = sh; eRet = 0; eFet = 0; eOwn = 0; eErr = 0; eInv = '0;
    tag = "R9";
    case (kind)
      0: begin
        eRet = 1;
        if (st == S_UNC)      begin nsh = rm; nst = S_SHR; tag = "R2"; end
        else if (st == S_SHR) begin nsh = sh | rm; tag = "R4"; end
        else begin eFet = 1; eOwn = own; nsh = sh | rm; nst = S_SHR; tag = "R6"; end
      end
      1: begin
        eRet = 1; nsh = rm; nst = S_EXC;
        if (st == S_UNC)      tag = "R3";
        else if (st == S_SHR) begin eInv = sh & ~rm; tag = "R5"; end
        else begin eFet = 1; eOwn = own; eInv = sh & ~rm; tag = "R7"; end
      end
      2: begin
        if (st == S_EXC && sh[c]) begin nsh = '0; nst = S_UNC; tag = "R8"; end
        else eErr = 1;
      end
      default: eErr = 1;
    endcase
    reqValid = 1'b1; reqKind = 2'(kind); reqCache = CW'(c); reqIndex = XW'(idx);
    @(negedge clk);
    reqValid = 1'b0;
    check("R10", "ackValid", ackValid, 1);
    check(tag, "ackReturn", ackReturn, eRet);
    check(tag, "ackFetch", ackFetch, eFet);
    check(tag, "ackInvMask", ackInvMask, eInv);
    check(tag, "ackOwner", ackOwner, eOwn);
    check(tag, "ackError", ackError, eErr);
    check("R12", "requester in mask", ackInvMask[c], 0);
    mSt[idx] = nst; mSh[idx] = nsh;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    @(negedge clk);
    doReset();

    // R1: first access to every entry behaves as no cached copy
    for (int e = 0; e < NE; e++) doReq(0, e % NC, e);

    // R10: idle cycle
    @(negedge clk);
    check("R10", "idle ackValid", ackValid, 0);
    check("R10", "idle ackReturn", ackReturn, 0);

    // near-exhaustive sweep: start state x kind x requester x owner
    for (int setup = 0; setup < 3; setup++)
      for (int k = 0; k < 4; k++)
        for (int c = 0; c < NC; c++)
          for (int o = 0; o < NC; o++) begin
            int idx = (k * NC + c + o) % NE;
            doReq(1, o, idx);
            if (setup == 0) doReq(2, o, idx);
            else if (setup == 1) doReq(0, (o + 1) % NC, idx);
            doReq(k, c, idx);
          end

    // R9: stray write-back leaves the owner in place
    doReq(1, 2, 1);
    doReq(2, 3, 1);
    doReq(0, 0, 1);
    check("R9", "owner kept after stray write-back", ackOwner, 2);

    // R11: independence of entries
    doReset();
    doReq(1, 1, 0);
    doReq(0, 2, 1);
    check("R11", "other entry fetch", ackFetch, 0);
    check("R11", "other entry owner", ackOwner, 0);

    // pseudo-random stream with idle gaps
    lf = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      int kind, c, idx;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      kind = int'(lf[1:0]); c = int'(lf[3:2]); idx = int'(lf[5:4]);
      if (kind == 2 && lf[7:6] != 2'b00 && mSt[idx] == S_EXC) c = lowBit(mSh[idx]);
      if (lf[11:8] == 4'h0) begin
        @(negedge clk);
        check("R10", "gap ackValid", ackValid, 0);
      end else begin
        doReq(kind, c, idx);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule